// File: doc/BRIEF.md
# Boundary-Scan Instruction and Data-Path Unit

This block holds the data-register side of a test access port. A separate TAP controller supplies one-cycle state strobes and the instruction code, and a separate instruction register supplies its own serial output. From these the block keeps a small instruction-mode state machine and routes the serial chain through one of three registers: a 32-bit identification register, a one-bit bypass register, or the boundary-scan register. The boundary-scan register covers every core input pin, every core output pin and one extra cell that gates the output bus.

The block also sits between the core and the output pads. In normal operation the core's data and enable reach the pins unchanged. Under the external-drive instruction the pins take their values from the boundary-scan update latch, and the gating cell decides whether the bus drives. Under the float-and-sample instruction the bus is held at high impedance until another instruction is loaded.

The mode state machine has five states: `ST_IDCODE`, `ST_BYPASS`, `ST_SAMPLE`, `ST_EXTEST` and `ST_SAMPLEZ`. An asynchronous reset or the Test-Logic-Reset strobe sends any state to `ST_IDCODE`. The Update-IR strobe sends any state to the state that the instruction code decodes to. In every other cycle the state holds.

Top module: `bscan_dr_unit`

## Requirements
- R1: After reset and in the cycle after a Test-Logic-Reset strobe, the identification instruction is active and the pins carry `core_out`/`core_oe`. A Capture-DR followed by Shift-DR then sends out the 32-bit ID value (default 32'h1A2B3C4D, bit 0 always 1) least-significant bit first.
- R2: The active instruction changes only on a rising `tck` edge where `upd_ir` is high. The codes are 3'b000 external drive, 3'b001 identification, 3'b010 float-and-sample, 3'b100 sample/preload and 3'b111 bypass.
- R3: Under bypass, Capture-DR loads 0 into the one-bit register, and Shift-DR returns `tdi` one bit later.
- R4: Codes 3'b011, 3'b101 and 3'b110 act exactly like bypass and leave the pins in functional mode.
- R5: Under sample/preload, Capture-DR loads the boundary register with `core_in` in bits 0..71, `pin_out` in bits 72..107 and `pin_oe` in bit 108. Shift-DR moves bit 0 to TDO and enters `tdi` at bit 108.
- R6: An Update-DR under sample/preload or external drive copies bits 72..108 of the shift stage into the update latch. Outside external drive and float-and-sample, the latch has no effect on the pins.
- R7: Under external drive, `pin_out` equals latch bits 72..107, `pin_oe` equals the latched bit 108, and the boundary register is the serial path.
- R8: Reset and Test-Logic-Reset set the latched bit 108 to 1 and the latched output bits to 0. An Update-DR under any other instruction leaves the latch unchanged.
- R9: Under float-and-sample, `pin_oe` is 0 from the cycle after Update-IR until the next Update-IR, and the boundary register is the serial path.
- R10: TDO changes only on the falling `tck` edge. `tdo_en` is high only after a falling edge where Shift-DR or Shift-IR is high. In Shift-IR, `tdo` follows `ir_so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset (power-up) |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| cap_dr | input | 1 | TAP is in Capture-DR |
| sh_dr | input | 1 | TAP is in Shift-DR |
| upd_dr | input | 1 | TAP is in Update-DR |
| upd_ir | input | 1 | TAP is in Update-IR |
| sh_ir | input | 1 | TAP is in Shift-IR |
| ir_code | input | 3 | Instruction register contents |
| ir_so | input | 1 | Serial output of the instruction register |
| tdi | input | 1 | Test data in |
| core_in | input | 72 | Core-side input pin values |
| core_out | input | 36 | Functional output data from the core |
| core_oe | input | 1 | Functional output-bus enable from the core |
| tdo | output | 1 | Test data out |
| tdo_en | output | 1 | TDO driver enable |
| pin_out | output | 36 | Data to the output pads |
| pin_oe | output | 1 | Output-bus enable to the pads |

## Verification
A mode register that misses or mis-decodes an Update-IR is visible at once. In the cycle after the strobe, `pin_oe` and `pin_out` either follow the core or follow the latch, so the error shows in the very next cycle. A corrupted shift or update stage stays hidden until it is shifted out or selected for drive. For that reason every latch load is later shifted back or driven under external drive, which brings each stored bit to TDO or to the pins within one scan length. A TDO path that moves on the wrong edge shows up half a cycle early, and the monitor samples just after each falling edge to catch it.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

    typedef enum logic [2:0] {
        ST_IDCODE  = 3'd0,
        ST_BYPASS  = 3'd1,
        ST_SAMPLE  = 3'd2,
        ST_EXTEST  = 3'd3,
        ST_SAMPLEZ = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        PATH_ID  = 2'd0,
        PATH_BYP = 2'd1,
        PATH_BSR = 2'd2
    } path_e;

endpackage

// File: rtl/bscan_mode_fsm.sv
module bscan_mode_fsm
    import bscan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tlr,
    input  logic            upd_ir,
    input  logic [IR_W-1:0] ir_code,
    output mode_e           mode_q,
    output path_e           dr_path,
    output logic            drive_latch,
    output logic            float_bus,
    output logic            latch_en
);

    mode_e mode_d;

    // Next-state decode: reset of the TAP wins over an instruction update.
    always_comb begin
        mode_d = mode_q;
        if (tlr) begin
            mode_d = ST_IDCODE;
        end else if (upd_ir) begin
            unique case (ir_code)
                OP_EXTEST:  mode_d = ST_EXTEST;
                OP_IDCODE:  mode_d = ST_IDCODE;
                OP_SAMPLEZ: mode_d = ST_SAMPLEZ;
                OP_SAMPLE:  mode_d = ST_SAMPLE;
                OP_BYPASS:  mode_d = ST_BYPASS;
                default:    mode_d = ST_BYPASS;
            endcase
        end
    end

    // State register.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            mode_q <= ST_IDCODE;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Mode-dependent controls.
    always_comb begin
        dr_path     = PATH_BYP;
        drive_latch = 1'b0;
        float_bus   = 1'b0;
        latch_en    = 1'b0;
        unique case (mode_q)
            ST_IDCODE: begin
                dr_path = PATH_ID;
            end
            ST_BYPASS: begin
                dr_path = PATH_BYP;
            end
            ST_SAMPLE: begin
                dr_path  = PATH_BSR;
                latch_en = 1'b1;
            end
            ST_EXTEST: begin
                dr_path     = PATH_BSR;
                drive_latch = 1'b1;
                latch_en    = 1'b1;
            end
            ST_SAMPLEZ: begin
                dr_path   = PATH_BSR;
                float_bus = 1'b1;
            end
            default: begin
                dr_path = PATH_BYP;
            end
        endcase
    end

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr #(
    parameter int N_IN  = 72,
    parameter int N_OUT = 36
) (
    input  logic                       tck,
    input  logic                       trst_n,
    input  logic                       tlr,
    input  logic                       cap,
    input  logic                       shift,
    input  logic                       upd,
    input  logic                       latch_en,
    input  logic                       tdi,
    input  logic [N_IN+N_OUT:0]        cap_vec,
    output logic                       so,
    output logic [N_OUT-1:0]           lat_out,
    output logic                       lat_ctl
);

    localparam int LEN   = N_IN + N_OUT + 1;
    localparam int CTL   = LEN - 1;
    localparam int LAT_W = N_OUT + 1;

    logic [LEN-1:0]   sr_q;
    logic [LAT_W-1:0] lat_q;

    // Shift stage: parallel capture, or shift toward bit 0.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= '0;
        end else if (cap) begin
            sr_q <= cap_vec;
        end else if (shift) begin
            sr_q <= {tdi, sr_q[LEN-1:1]};
        end
    end

    // Update latch: only the output cells and the bus-gating cell are kept.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            lat_q <= {1'b1, {N_OUT{1'b0}}};
        end else if (tlr) begin
            lat_q <= {1'b1, {N_OUT{1'b0}}};
        end else if (upd && latch_en) begin
            lat_q <= sr_q[CTL:N_IN];
        end
    end

    assign so      = sr_q[0];
    assign lat_out = lat_q[N_OUT-1:0];
    assign lat_ctl = lat_q[N_OUT];

endmodule

// File: rtl/bscan_idbyp.sv
module bscan_idbyp
    import bscan_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A2B3C4D
) (
    input  logic tck,
    input  logic trst_n,
    input  logic cap_id,
    input  logic sh_id,
    input  logic cap_byp,
    input  logic sh_byp,
    input  logic tdi,
    output logic id_so,
    output logic byp_so
);

    localparam logic [ID_W-1:0] ID_EFF = {ID_VALUE[ID_W-1:1], 1'b1};

    logic [ID_W-1:0] id_q;
    logic            byp_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_q <= ID_EFF;
        end else if (cap_id) begin
            id_q <= ID_EFF;
        end else if (sh_id) begin
            id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (cap_byp) begin
            byp_q <= 1'b0;
        end else if (sh_byp) begin
            byp_q <= tdi;
        end
    end

    assign id_so  = id_q[0];
    assign byp_so = byp_q;

endmodule

// File: rtl/bscan_dr_unit.sv
module bscan_dr_unit
    import bscan_pkg::*;
#(
    parameter int              N_IN     = 72,
    parameter int              N_OUT    = 36,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A2B3C4D
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tlr,
    input  logic              cap_dr,
    input  logic              sh_dr,
    input  logic              upd_dr,
    input  logic              upd_ir,
    input  logic              sh_ir,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              ir_so,
    input  logic              tdi,
    input  logic [N_IN-1:0]   core_in,
    input  logic [N_OUT-1:0]  core_out,
    input  logic              core_oe,
    output logic              tdo,
    output logic              tdo_en,
    output logic [N_OUT-1:0]  pin_out,
    output logic              pin_oe
);

    localparam int LEN = N_IN + N_OUT + 1;

    mode_e            mode_q;
    path_e            dr_path;
    logic             drive_latch;
    logic             float_bus;
    logic             latch_en;
    logic             sel_id;
    logic             sel_byp;
    logic             sel_bsr;
    logic             bsr_so;
    logic             id_so;
    logic             byp_so;
    logic [N_OUT-1:0] lat_out;
    logic             lat_ctl;
    logic [LEN-1:0]   cap_vec;
    logic             dr_bit;
    logic             tdo_q;
    logic             tdo_en_q;

    bscan_mode_fsm u_fsm (
        .tck         (tck),
        .trst_n      (trst_n),
        .tlr         (tlr),
        .upd_ir      (upd_ir),
        .ir_code     (ir_code),
        .mode_q      (mode_q),
        .dr_path     (dr_path),
        .drive_latch (drive_latch),
        .float_bus   (float_bus),
        .latch_en    (latch_en)
    );

    assign sel_id  = (dr_path == PATH_ID);
    assign sel_byp = (dr_path == PATH_BYP);
    assign sel_bsr = (dr_path == PATH_BSR);

    // Pad multiplexing: core, latch drive, or forced float.
    always_comb begin
        if (drive_latch) begin
            pin_out = lat_out;
            pin_oe  = lat_ctl;
        end else begin
            pin_out = core_out;
            pin_oe  = float_bus ? 1'b0 : core_oe;
        end
    end

    // Capture snapshot: inputs low, pad outputs above, bus enable on top.
    assign cap_vec = {pin_oe, pin_out, core_in};

    bscan_bsr #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT)
    ) u_bsr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tlr      (tlr),
        .cap      (cap_dr && sel_bsr && !tlr),
        .shift    (sh_dr && sel_bsr && !tlr),
        .upd      (upd_dr),
        .latch_en (latch_en),
        .tdi      (tdi),
        .cap_vec  (cap_vec),
        .so       (bsr_so),
        .lat_out  (lat_out),
        .lat_ctl  (lat_ctl)
    );

    bscan_idbyp #(
        .ID_VALUE (ID_VALUE)
    ) u_idbyp (
        .tck     (tck),
        .trst_n  (trst_n),
        .cap_id  (cap_dr && sel_id),
        .sh_id   (sh_dr && sel_id),
        .cap_byp (cap_dr && sel_byp),
        .sh_byp  (sh_dr && sel_byp),
        .tdi     (tdi),
        .id_so   (id_so),
        .byp_so  (byp_so)
    );

    always_comb begin
        unique case (dr_path)
            PATH_ID:  dr_bit = id_so;
            PATH_BYP: dr_bit = byp_so;
            PATH_BSR: dr_bit = bsr_so;
            default:  dr_bit = byp_so;
        endcase
    end

    // Serial output retimed to the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q    <= 1'b0;
            tdo_en_q <= 1'b0;
        end else begin
            tdo_en_q <= sh_dr || sh_ir;
            if (sh_ir) begin
                tdo_q <= ir_so;
            end else if (sh_dr) begin
                tdo_q <= dr_bit;
            end
        end
    end

    assign tdo    = tdo_q;
    assign tdo_en = tdo_en_q;

endmodule

// File: rtl/bscan_dr_unit_chk.sv
module bscan_dr_unit_chk
    import bscan_pkg::*;
#(
    parameter int N_OUT = 36
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tlr,
    input logic             upd_ir,
    input logic             upd_dr,
    input logic             cap_dr,
    input logic [IR_W-1:0]  ir_code,
    input logic [N_OUT-1:0] core_out,
    input logic             core_oe,
    input logic [N_OUT-1:0] pin_out,
    input logic             pin_oe,
    input mode_e            mode_q,
    input logic             byp_so,
    input logic [N_OUT-1:0] lat_out,
    input logic             lat_ctl
);

    // R1
    tlr_functional_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (pin_oe == core_oe && pin_out == core_out));

    // R2
    mode_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (!tlr && !upd_ir) |=> $stable(mode_q));

    // R3
    byp_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && !tlr && !upd_ir && mode_q == ST_BYPASS) |=> (byp_so == 1'b0));

    // R9
    float_bus_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (upd_ir && !tlr && ir_code == OP_SAMPLEZ) |=> !pin_oe);

    // R8
    latch_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (!tlr && !(upd_dr && (mode_q == ST_SAMPLE || mode_q == ST_EXTEST)))
        |=> ($stable(lat_out) && $stable(lat_ctl)));

    // R8
    ctl_preset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (lat_ctl && lat_out == '0));

endmodule

bind bscan_dr_unit bscan_dr_unit_chk #(
    .N_OUT (N_OUT)
) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tlr      (tlr),
    .upd_ir   (upd_ir),
    .upd_dr   (upd_dr),
    .cap_dr   (cap_dr),
    .ir_code  (ir_code),
    .core_out (core_out),
    .core_oe  (core_oe),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .mode_q   (mode_q),
    .byp_so   (byp_so),
    .lat_out  (lat_out),
    .lat_ctl  (lat_ctl)
);

// File: tb/bscan_dr_unit_test.sv
module bscan_dr_unit_test;
    import bscan_pkg::*;

    localparam int NI  = 72;
    localparam int NO  = 36;
    localparam int LEN = NI + NO + 1;
    localparam logic [31:0] IDV = 32'h1A2B3C4D;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tlr = 1'b0, cap_dr = 1'b0, sh_dr = 1'b0, upd_dr = 1'b0;
    logic          upd_ir = 1'b0, sh_ir = 1'b0, ir_so = 1'b0, tdi = 1'b0;
    logic [2:0]    ir_code = OP_IDCODE;
    logic [NI-1:0] core_in = 72'hC3_1122_3344_5566_7788;
    logic [NO-1:0] core_out = 36'h9_8765_4321;
    logic          core_oe = 1'b1;
    logic          tdo, tdo_en, pin_oe;
    logic [NO-1:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic v;
        int   r;
    } exp_t;
    exp_t sb[$];

    always #5 tck = ~tck;

    bscan_dr_unit uut (
        .tck(tck), .trst_n(trst_n), .tlr(tlr), .cap_dr(cap_dr), .sh_dr(sh_dr),
        .upd_dr(upd_dr), .upd_ir(upd_ir), .sh_ir(sh_ir), .ir_code(ir_code),
        .ir_so(ir_so), .tdi(tdi), .core_in(core_in), .core_out(core_out),
        .core_oe(core_oe), .tdo(tdo), .tdo_en(tdo_en), .pin_out(pin_out),
        .pin_oe(pin_oe)
    );

    task automatic chk(input logic [127:0] act, input logic [127:0] exp, input int r);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic load_ir(input logic [2:0] code);
        ir_code = code;
        upd_ir  = 1'b1;
        step();
        upd_ir  = 1'b0;
    endtask

    task automatic capture();
        cap_dr = 1'b1;
        step();
        cap_dr = 1'b0;
    endtask

    task automatic update();
        upd_dr = 1'b1;
        step();
        upd_dr = 1'b0;
    endtask

    // Driver: pushes expected TDO bits, drives TDI.
    task automatic shift(input int n, input logic [LEN-1:0] din,
                         input logic [LEN-1:0] exp, input int r);
        sh_dr = 1'b1;
        for (int i = 0; i < n; i++) begin
            tdi = din[i];
            sb.push_back('{v: exp[i], r: r});
            step();
        end
        sh_dr = 1'b0;
    endtask

    // Monitor: compares TDO just after each falling edge of a shift cycle (R10).
    always @(negedge tck) begin
        #2;
        if (sh_dr && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({127'b0, tdo}, {127'b0, e.v}, e.r);
            chk({127'b0, tdo_en}, 128'd1, 10);
        end
    end

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] p1, p2, p3, ex;
        repeat (3) @(posedge tck);
        #1;
        trst_n = 1'b1;
        step();

        // R1 reset state: functional pins, TDO disabled (R10)
        chk({127'b0, tdo_en}, 128'd0, 10);
        chk({92'b0, pin_out}, {92'b0, core_out}, 1);
        chk({127'b0, pin_oe}, {127'b0, core_oe}, 1);

        // R2: code present without the update strobe changes nothing
        ir_code = OP_BYPASS;
        step();
        // R1: ID value out LSB first
        capture();
        sh_dr = 1'b1;
        #1;
        chk({127'b0, tdo_en}, 128'd0, 10);   // R10: not before the falling edge
        shift(32, '0, {{(LEN-32){1'b0}}, IDV}, 1);
        step();
        chk({127'b0, tdo_en}, 128'd0, 10);

        // R3 bypass: captured 0, then TDI delayed by one
        load_ir(OP_BYPASS);
        capture();
        shift(8, {{(LEN-8){1'b0}}, 8'b1011_0010},
                 {{(LEN-8){1'b0}}, 8'b0110_0100}, 3);

        // R5 sample/preload capture with simultaneous preload
        load_ir(OP_SAMPLE);
        chk({92'b0, pin_out}, {92'b0, core_out}, 6);
        capture();
        p1 = {1'b1, 36'hA_5A5A_5A5A, 72'h0};
        shift(LEN, p1, {1'b1, core_out, core_in}, 5);
        update();
        // R6: latch ignored outside external drive
        chk({92'b0, pin_out}, {92'b0, core_out}, 6);
        chk({127'b0, pin_oe}, {127'b0, core_oe}, 6);

        // R7 external drive from latch
        load_ir(OP_EXTEST);
        chk({92'b0, pin_out}, {92'b0, 36'hA_5A5A_5A5A}, 7);
        chk({127'b0, pin_oe}, 128'd1, 7);
        p2 = {1'b0, 36'h0_F0F0_F0F0, 72'hFF_0000_0000_0000_00FF};
        shift(LEN, p2, p1, 7);
        update();
        chk({92'b0, pin_out}, {92'b0, 36'h0_F0F0_F0F0}, 7);
        chk({127'b0, pin_oe}, 128'd0, 7);

        // R1 Test-Logic-Reset returns pins to the core
        tlr = 1'b1;
        step();
        tlr = 1'b0;
        chk({92'b0, pin_out}, {92'b0, core_out}, 1);
        chk({127'b0, pin_oe}, {127'b0, core_oe}, 1);
        // R8 preset latch
        load_ir(OP_EXTEST);
        chk({92'b0, pin_out}, 128'd0, 8);
        chk({127'b0, pin_oe}, 128'd1, 8);

        // R4 reserved code behaves as bypass
        load_ir(3'b011);
        chk({92'b0, pin_out}, {92'b0, core_out}, 4);
        chk({127'b0, pin_oe}, {127'b0, core_oe}, 4);
        capture();
        shift(4, {{(LEN-4){1'b0}}, 4'b1011}, {{(LEN-4){1'b0}}, 4'b0110}, 4);

        // R9 float-and-sample
        load_ir(OP_SAMPLEZ);
        chk({127'b0, pin_oe}, 128'd0, 9);
        core_out = 36'h1_2345_6789;
        core_in  = 72'h00_FF00_FF00_FF00_FF00;
        core_oe  = 1'b1;
        step();
        chk({127'b0, pin_oe}, 128'd0, 9);
        capture();
        p3 = {1'b1, 36'hF_FFFF_FFFF, 72'h0};
        ex = {1'b0, 36'h1_2345_6789, 72'h00_FF00_FF00_FF00_FF00};
        shift(LEN, p3, ex, 9);
        update();
        // R2: new code without strobe keeps the float
        ir_code = OP_IDCODE;
        step();
        step();
        chk({127'b0, pin_oe}, 128'd0, 2);
        // R8: update under float-and-sample left the latch alone
        load_ir(OP_EXTEST);
        chk({92'b0, pin_out}, 128'd0, 8);
        chk({127'b0, pin_oe}, 128'd1, 8);
        load_ir(OP_IDCODE);
        chk({127'b0, pin_oe}, {127'b0, core_oe}, 2);

        // R10 Shift-IR passes ir_so
        sh_ir = 1'b1;
        ir_so = 1'b1;
        @(negedge tck);
        #1;
        chk({127'b0, tdo}, 128'd1, 10);
        chk({127'b0, tdo_en}, 128'd1, 10);
        step();
        sh_ir = 1'b0;
        ir_so = 1'b0;
        @(negedge tck);
        #1;
        chk({127'b0, tdo_en}, 128'd0, 10);
        chk({127'b0, tdo}, 128'd1, 10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule